// File: doc/BRIEF.md
# FIFO Level, Threshold and Receive-Timeout Event Controller

This block sits between a host register interface and the serial shift registers of an infrared link controller. It holds one 32-entry by 8-bit FIFO that is shared by both directions. The host or the receive shift register fills it, and the host or the transmit shift register drains it. The block reports the fill level and compares it against two programmable 4-bit threshold codes, one for transmit and one for receive. It also runs a receive inactivity timer and keeps an eight-bit event register with a matching enable register. Together these drive a single active-low interrupt line.

Some event bits are sticky and clear when the host reads the event register. Two event bits follow the FIFO level directly. The receive timeout counts bit-time ticks in the two low-speed modes. In the two high-speed modes it counts a fixed number of clock cycles, set by a parameter.

Top module: `ifc_top`

## Requirements
- R1: After reset the level is 0, the timeout flag is 0, every sticky event bit and every enable bit is 0, `thr_o` is 8'h77, and `irq_no` is 1.
- R2: Bytes leave the FIFO (`head_o`, popped by `data_rd_i` or `tx_pop_i`) in the order they were pushed. The level in `status_o[7:2]` runs from 0 to 32. A host write while the level is 32 is dropped and the level stays 32.
- R3: A threshold code c decodes to 1 byte when c is 0 and to 2*c bytes otherwise. The transmit code is `thr_o[3:0]` and the receive code is `thr_o[7:4]`. Both are written together from `wdata_i` by `thr_wr_i`.
- R4: Event bit 6 is 1 exactly while the level is below the decoded transmit threshold.
- R5: Event bit 5 is 1 while the level is at or above the decoded receive threshold, or while the timeout flag is set.
- R6: In modes 0 and 1 (`mode_i[1]`=0), the timeout flag (`status_o[0]`) sets on the 32nd `baud_tick_i` counted while the level is nonzero and no receive push or host data read has occurred. Each receive push or host read restarts the count.
- R7: In modes 2 and 3 (`mode_i[1]`=1), the timeout flag sets after HS_TIMEOUT_CYC clock cycles under the same conditions as R6.
- R8: A host data read (`data_rd_i`) clears the timeout flag on the next edge.
- R9: A receive push while the level is 32 sets event bit 1 (overrun). The byte is not stored, and the level and FIFO contents stay unchanged.
- R10: Event bits 7, 4, 3, 2, 1 and 0 are sticky and clear when `evt_rd_i` is pulsed. A set condition in the same cycle as the read wins. Bit 0 is set by `sym_err_i`, bit 2 by `crc_err_i`, bit 3 by `len_err_i` and bit 4 by `eof_i`.
- R11: Event bit 7 sets while `tx_active_i` is 1, the FIFO is empty and `tx_shift_empty_i` is 1.
- R12: `irq_no` is 0 exactly when some bit is 1 in both `event_o` and `enable_o`. `enable_o` is loaded from `wdata_i` by `en_wr_i`.
- R13: `clr_i` empties the FIFO and clears the timeout flag. It leaves `thr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdata_i | input | 8 | Host write data for the FIFO, enable and threshold registers |
| data_wr_i | input | 1 | Host push of wdata_i into the FIFO |
| data_rd_i | input | 1 | Host pop of the FIFO head |
| head_o | output | 8 | Byte at the FIFO head |
| en_wr_i | input | 1 | Load the enable register |
| thr_wr_i | input | 1 | Load both threshold codes |
| evt_rd_i | input | 1 | Host read of the event register, which clears the sticky bits |
| rx_push_i | input | 1 | Receive shift register delivers a byte |
| rx_byte_i | input | 8 | Byte from the receive shift register |
| tx_pop_i | input | 1 | Transmit shift register takes the head byte |
| clr_i | input | 1 | Empty the FIFO |
| mode_i | input | 2 | Link mode; bit 1 selects the high-speed timeout |
| baud_tick_i | input | 1 | One pulse per bit time |
| tx_active_i | input | 1 | Sending mode is active |
| tx_shift_empty_i | input | 1 | Transmit shift register is empty |
| crc_err_i | input | 1 | CRC error pulse |
| len_err_i | input | 1 | Maximum-length error pulse |
| eof_i | input | 1 | End-of-frame pulse |
| sym_err_i | input | 1 | Framing, abort or encode error pulse |
| status_o | output | 8 | Level in bits 7:2, 0 in bit 1, timeout flag in bit 0 |
| event_o | output | 8 | Event register |
| enable_o | output | 8 | Enable register |
| thr_o | output | 8 | Threshold codes |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The threshold logic is tried with the transmit code at 3 and the receive codes at 0 and 15. The level is stepped across each decoded boundary, which separates the code-0 special case from the doubling rule and separates "below" from "at or above". The FIFO is filled with a distinct ramp, over-filled by both a host write and a receive push, and drained through both pop paths, which distinguishes ordering errors from overrun handling. The timeout is driven one tick short of its limit and then exactly to it, in both speed classes, and with a restarting push partway through; this tells an off-by-one limit from a missing restart. Sticky bits are read back alone and with a set pulse coincident with the read, so that the set-over-clear priority is observed.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  localparam int EV_TXE = 7;
  localparam int EV_TXL = 6;
  localparam int EV_RXH = 5;
  localparam int EV_EOF = 4;
  localparam int EV_MLE = 3;
  localparam int EV_CRC = 2;
  localparam int EV_OVR = 1;
  localparam int EV_SYM = 0;
  localparam logic [7:0] STICKY_MASK = 8'b1001_1111;
  localparam logic [7:0] THR_RESET   = 8'h77;

  // code 0 -> 1 byte, otherwise 2*code
  function automatic logic [4:0] thr_decode(input logic [3:0] code);
    return (code == 4'd0) ? 5'd1 : {code, 1'b0};
  endfunction
endpackage

// File: rtl/ifc_fifo.sv
module ifc_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] pdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic do_push, do_pop;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i & ~full_o & ~clr_i;
  assign do_pop  = pop_i & ~empty_o & ~clr_i;
  assign head_o  = mem[rd_ptr];
  assign count_o = cnt;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= pdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
  // R2
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !clr_i) |=> $stable(cnt));
endmodule

// File: rtl/ifc_timeout.sv
module ifc_timeout #(
  parameter int HS_CYC  = 3336000,
  parameter int LS_BITS = 32,
  localparam int LIM = (HS_CYC > LS_BITS) ? HS_CYC : LS_BITS,
  localparam int TW  = $clog2(LIM + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic flag_clr_i,
  input  logic held_i,
  input  logic fast_i,
  input  logic tick_i,
  output logic tout_o
);
  logic [TW-1:0] tm, lim;
  logic step;

  assign lim  = fast_i ? TW'(HS_CYC - 1) : TW'(LS_BITS - 1);
  assign step = fast_i | tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tm     <= '0;
      tout_o <= 1'b0;
    end else begin
      if (flag_clr_i) tout_o <= 1'b0;
      if (restart_i) begin
        tm <= '0;
      end else if (held_i && !tout_o && step) begin
        if (tm >= lim) begin
          tout_o <= 1'b1;
          tm     <= '0;
        end else begin
          tm <= tm + 1'b1;
        end
      end
    end
  end

  // R6
  tout_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tout_o) |-> $past(held_i));
  // R8
  tout_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i |=> !tout_o);
endmodule

// File: rtl/ifc_events.sv
module ifc_events
  import ifc_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] tx_thr_i,
  input  logic [CW-1:0] rx_thr_i,
  input  logic          tout_i,
  input  logic          txe_i,
  input  logic          ovr_i,
  input  logic          crc_i,
  input  logic          len_i,
  input  logic          eof_i,
  input  logic          sym_i,
  input  logic          rd_i,
  input  logic          en_wr_i,
  input  logic [7:0]    en_data_i,
  output logic [7:0]    events_o,
  output logic [7:0]    enable_o,
  output logic          irq_no
);
  logic [7:0] sticky_q, sets, level_bits;

  always_comb begin
    sets = '0;
    sets[EV_TXE] = txe_i;
    sets[EV_EOF] = eof_i;
    sets[EV_MLE] = len_i;
    sets[EV_CRC] = crc_i;
    sets[EV_OVR] = ovr_i;
    sets[EV_SYM] = sym_i;
    level_bits = '0;
    level_bits[EV_TXL] = (count_i < tx_thr_i);
    level_bits[EV_RXH] = (count_i >= rx_thr_i) | tout_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= '0;
      enable_o <= '0;
    end else begin
      sticky_q <= ((sticky_q & ~(rd_i ? STICKY_MASK : 8'h00)) | sets) & STICKY_MASK;
      if (en_wr_i) enable_o <= en_data_i;
    end
  end

  assign events_o = sticky_q | level_bits;
  assign irq_no   = ~|(events_o & enable_o);

  // R10
  sticky_rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sets == '0) |=> ((events_o & STICKY_MASK) == '0));
  // R11
  txe_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txe_i |=> events_o[EV_TXE]);
endmodule

// File: rtl/ifc_top.sv
module ifc_top
  import ifc_pkg::*;
#(
  parameter int DEPTH          = 32,
  parameter int DW             = 8,
  parameter int HS_TIMEOUT_CYC = 3336000,
  parameter int LS_BITS        = 32,
  localparam int CW            = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic          data_wr_i,
  input  logic          data_rd_i,
  output logic [DW-1:0] head_o,
  input  logic          en_wr_i,
  input  logic          thr_wr_i,
  input  logic          evt_rd_i,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_byte_i,
  input  logic          tx_pop_i,
  input  logic          clr_i,
  input  logic [1:0]    mode_i,
  input  logic          baud_tick_i,
  input  logic          tx_active_i,
  input  logic          tx_shift_empty_i,
  input  logic          crc_err_i,
  input  logic          len_err_i,
  input  logic          eof_i,
  input  logic          sym_err_i,
  output logic [7:0]    status_o,
  output logic [7:0]    event_o,
  output logic [7:0]    enable_o,
  output logic [7:0]    thr_o,
  output logic          irq_no
);
  logic [CW-1:0] count, tx_thr, rx_thr;
  logic full, empty, tout;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       thr_o <= THR_RESET;
    else if (thr_wr_i) thr_o <= wdata_i[7:0];
  end

  assign tx_thr = CW'(thr_decode(thr_o[3:0]));
  assign rx_thr = CW'(thr_decode(thr_o[7:4]));

  ifc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .push_i  (data_wr_i | rx_push_i),
    .pdata_i (data_wr_i ? wdata_i : rx_byte_i),
    .pop_i   (data_rd_i | tx_pop_i),
    .head_o  (head_o),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty)
  );

  ifc_timeout #(.HS_CYC(HS_TIMEOUT_CYC), .LS_BITS(LS_BITS)) u_tout (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (rx_push_i | data_rd_i | clr_i),
    .flag_clr_i (data_rd_i | clr_i),
    .held_i     (!empty),
    .fast_i     (mode_i[1]),
    .tick_i     (baud_tick_i),
    .tout_o     (tout)
  );

  ifc_events #(.CW(CW)) u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .count_i   (count),
    .tx_thr_i  (tx_thr),
    .rx_thr_i  (rx_thr),
    .tout_i    (tout),
    .txe_i     (tx_active_i & empty & tx_shift_empty_i),
    .ovr_i     (rx_push_i & full),
    .crc_i     (crc_err_i),
    .len_i     (len_err_i),
    .eof_i     (eof_i),
    .sym_i     (sym_err_i),
    .rd_i      (evt_rd_i),
    .en_wr_i   (en_wr_i),
    .en_data_i (wdata_i[7:0]),
    .events_o  (event_o),
    .enable_o  (enable_o),
    .irq_no    (irq_no)
  );

  assign status_o = {6'(count), 1'b0, tout};

  // R9
  overrun_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && full) |=> event_o[EV_OVR]);
  // R13
  clr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (status_o[7:2] == 6'd0 && !status_o[0]));
  // R13
  clr_keeps_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !thr_wr_i) |=> $stable(thr_o));
endmodule

// File: tb/tb_ifc_top.sv
`timescale 1ns/1ps
module tb_ifc_top;
  localparam int HS = 100;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] wdata_i = '0, rx_byte_i = '0;
  logic data_wr_i = 0, data_rd_i = 0, en_wr_i = 0, thr_wr_i = 0, evt_rd_i = 0;
  logic rx_push_i = 0, tx_pop_i = 0, clr_i = 0, baud_tick_i = 0;
  logic tx_active_i = 0, tx_shift_empty_i = 0;
  logic crc_err_i = 0, len_err_i = 0, eof_i = 0, sym_err_i = 0;
  logic [1:0] mode_i = 2'd0;
  logic [7:0] head_o, status_o, event_o, enable_o, thr_o;
  logic irq_no;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  ifc_top #(.HS_TIMEOUT_CYC(HS)) dut (
    .clk_i, .rst_ni, .wdata_i, .data_wr_i, .data_rd_i, .head_o, .en_wr_i,
    .thr_wr_i, .evt_rd_i, .rx_push_i, .rx_byte_i, .tx_pop_i, .clr_i, .mode_i,
    .baud_tick_i, .tx_active_i, .tx_shift_empty_i, .crc_err_i, .len_err_i,
    .eof_i, .sym_err_i, .status_o, .event_o, .enable_o, .thr_o, .irq_no
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic host_wr(input logic [7:0] b);
    wdata_i = b; data_wr_i = 1; cyc(); data_wr_i = 0;
  endtask

  task automatic host_rd(output logic [7:0] b);
    b = head_o; data_rd_i = 1; cyc(); data_rd_i = 0;
  endtask

  task automatic tx_take(output logic [7:0] b);
    b = head_o; tx_pop_i = 1; cyc(); tx_pop_i = 0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    rx_byte_i = b; rx_push_i = 1; cyc(); rx_push_i = 0;
  endtask

  task automatic set_thr(input logic [7:0] v);
    wdata_i = v; thr_wr_i = 1; cyc(); thr_wr_i = 0;
  endtask

  task automatic set_en(input logic [7:0] v);
    wdata_i = v; en_wr_i = 1; cyc(); en_wr_i = 0;
  endtask

  task automatic evt_read();
    evt_rd_i = 1; cyc(); evt_rd_i = 0;
  endtask

  task automatic fifo_clr();
    clr_i = 1; cyc(); clr_i = 0;
  endtask

  task automatic tick();
    baud_tick_i = 1; cyc(); baud_tick_i = 0;
  endtask

  task automatic t_reset();
    settle();
    check("R1 level", status_o, 8'h00);
    check("R1 events", event_o, 8'h40); // only level-tracking txl: 0 < 14
    check("R1 enable", enable_o, 8'h00);
    check("R1 thr", thr_o, 8'h77);
    check("R1 irq", irq_no, 1);
  endtask

  task automatic t_thresholds();
    set_thr(8'h03); // tx code 3 -> 6, rx code 0 -> 1
    for (int i = 0; i < 5; i++) host_wr(8'(i));
    settle();
    check("R4 txl below", event_o[6], 1);
    check("R5 rxh code0", event_o[5], 1);
    host_wr(8'h05);
    settle();
    check("R3 R4 txl at 6", event_o[6], 0);
    check("R2 level 6", status_o[7:2], 6);
    set_thr(8'hF3); // rx code 15 -> 30
    settle();
    check("R3 R5 rxh below 30", event_o[5], 0);
    fifo_clr();
    settle();
    check("R13 level after clear", status_o[7:2], 0);
    check("R13 thr kept", thr_o, 8'hF3);
    set_thr(8'h77);
  endtask

  task automatic t_order_full();
    logic [7:0] b;
    for (int i = 0; i < 32; i++) host_wr(8'(i * 3 + 1));
    settle();
    check("R2 level full", status_o[7:2], 32);
    host_wr(8'hAA);
    settle();
    check("R2 write when full", status_o[7:2], 32);
    check("R9 no overrun yet", event_o[1], 0);
    rx_push(8'hEE);
    settle();
    check("R9 overrun set", event_o[1], 1);
    check("R9 level", status_o[7:2], 32);
    for (int i = 0; i < 32; i++) begin
      if (i % 2 == 0) host_rd(b); else tx_take(b);
      check($sformatf("R2 R9 order %0d", i), b, 8'(i * 3 + 1));
    end
    settle();
    check("R2 level empty", status_o[7:2], 0);
    evt_read();
    settle();
    check("R10 overrun cleared", event_o[1], 0);
  endtask

  task automatic t_timeout_low();
    logic [7:0] b;
    mode_i = 2'd0;
    rx_push(8'h11);
    repeat (31) tick();
    settle();
    check("R6 tout 31 ticks", status_o[0], 0);
    tick();
    settle();
    check("R6 tout 32 ticks", status_o[0], 1);
    check("R5 rxh by timeout", event_o[5], 1);
    host_rd(b);
    settle();
    check("R8 tout cleared", status_o[0], 0);
    check("R8 rxh cleared", event_o[5], 0);
    rx_push(8'h22);
    repeat (20) tick();
    rx_push(8'h33);
    repeat (20) tick();
    settle();
    check("R6 restart by push", status_o[0], 0);
    repeat (12) tick();
    settle();
    check("R6 tout after restart", status_o[0], 1);
    fifo_clr();
    settle();
    check("R13 clear drops tout", status_o[0], 0);
  endtask

  task automatic t_timeout_high();
    mode_i = 2'd2;
    rx_push(8'h44);
    repeat (HS - 1) cyc();
    settle();
    check("R7 tout one short", status_o[0], 0);
    cyc();
    settle();
    check("R7 tout at limit", status_o[0], 1);
    fifo_clr();
    mode_i = 2'd0;
  endtask

  task automatic t_sticky();
    crc_err_i = 1; len_err_i = 1; eof_i = 1; sym_err_i = 1; cyc();
    crc_err_i = 0; len_err_i = 0; eof_i = 0; sym_err_i = 0;
    settle();
    check("R10 sticky set", event_o & 8'h9F, 8'h1D);
    evt_read();
    settle();
    check("R10 sticky cleared", event_o & 8'h9F, 8'h00);
    evt_rd_i = 1; crc_err_i = 1; cyc(); evt_rd_i = 0; crc_err_i = 0;
    settle();
    check("R10 set wins over read", event_o[2], 1);
    evt_read();
  endtask

  task automatic t_txe();
    tx_active_i = 1; tx_shift_empty_i = 1; cyc();
    settle();
    check("R11 txe set", event_o[7], 1);
    tx_active_i = 0; cyc();
    settle();
    check("R11 txe sticky", event_o[7], 1);
    evt_read();
    settle();
    check("R10 R11 txe cleared", event_o[7], 0);
    tx_shift_empty_i = 0;
  endtask

  task automatic t_irq();
    set_en(8'h40);
    settle();
    check("R12 irq by txl", irq_no, 0);
    set_en(8'h04);
    settle();
    check("R12 irq masked", irq_no, 1);
    crc_err_i = 1; cyc(); crc_err_i = 0;
    settle();
    check("R12 irq by crc", irq_no, 0);
    check("R12 enable readback", enable_o, 8'h04);
    evt_read();
    settle();
    check("R12 irq released", irq_no, 1);
  endtask

  initial begin
    repeat (3) cyc();
    rst_ni = 1;
    cyc();
    t_reset();
    t_thresholds();
    t_order_full();
    t_timeout_low();
    t_timeout_high();
    t_sticky();
    t_txe();
    t_irq();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule